// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. On the memory side it drives active-low chip select, write strobe and output enable, a 15-bit address and a bidirectional 8-bit data bus that it tri-states. On the host side it offers a request/ready handshake with a write flag, an address and write data, and it returns read data with a one-cycle valid strobe.

The device's timing minimums are given in nanoseconds as parameters, alongside the clock period. At elaboration each one becomes a whole number of cycles by ceiling division, with a floor of one cycle. The sequencer derives four things from these counts: the write strobe length, the point inside the strobe where its own bus driver may turn on, the recovery tail, and the read capture edge. When the previous operation was a read, the turnaround before driving the bus is stretched to cover the device's output-disable delay. Between operations chip select returns high, which puts the memory into its low-power standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: A synchronous active-high reset sets chip select, write strobe and output enable high (inactive), turns off the bus driver, drops the read-valid strobe and leaves ready high.
- R2: Whenever ready is high (controller idle), chip select is high (standby).
- R3: The write strobe is low only while chip select is low and output enable is high. Output enable is low only while chip select is low, the write strobe is high and the controller does not drive the bus.
- R4: The memory address is taken from the host on the accepting edge. It does not change while the write strobe is low, nor on the edge where the strobe rises.
- R5: During a write the bus driver turns on no earlier than TURN cycles after the write strobe falls, where TURN = ceil(T_WHZ_NS / period), which is 3 at the defaults. It turns off on the same edge that raises the strobe.
- R6: The write strobe stays low for PULSE = max(ceil(T_WP), TURN + ceil(T_DW), ceil(T_AW) - 1) cycles, which is 7 at the defaults. The driver is on for the last PULSE - TURN of these cycles, which is at least ceil(T_DW) and is 4 at the defaults.
- R7: A read holds chip select and output enable low from the accepting edge and captures the bus on the N-th following edge, where N = max(ceil(T_AA), ceil(T_OE)), which is 7 at the defaults. Read-valid is high for exactly the one cycle after that edge.
- R8: A read returns the byte most recently written to that address.
- R9: A request is accepted only on an edge where ready is high. Ready is low from the accepting edge until the operation ends, and a request presented while ready is low is ignored.
- R10: A write keeps ready low for 1 + PULSE + TAIL cycles, where TAIL = max(1, ceil(T_WC) - 1 - PULSE). At the defaults this is 9 cycles. A read keeps ready low for at least ceil(T_RC) cycles.
- R11: When turnaround tracking is enabled (the default) and the previous operation was a read, TURN becomes max(ceil(T_WHZ), ceil(T_OHZ)) = 4. The write strobe then lasts 8 cycles and the write keeps ready low for 10 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| rd_valid | output | 1 | One-cycle strobe, rd_data is valid |
| rd_data | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data bus, tri-stated by the controller |

## Verification
The bench's memory model returns corrupted data until output enable has been low for the full access time. A controller that captured one edge early would therefore return wrong read data. The bench counts write-strobe cycles and the cycle where the controller's data first appears on the bus. It does this both after a write and after a read, so a design that drives the bus too soon or ignores the read-to-write turnaround shows up with a wrong count. A request held high during a busy write to another address must leave that address untouched; a design that latched it would corrupt the location, and a read-back exposes it.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WRECOV,
      ST_RACCESS,
      ST_RTAIL
   } seq_state_e;

   // nanoseconds to whole cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
      int unsigned c;
      c = (t_ns + per_ns - 1) / per_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_down_timer.sv
`timescale 1ns/1ps
module sram_down_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int N_WP       = 5,
   parameter int N_DW       = 4,
   parameter int N_WHZ      = 3,
   parameter int N_OHZ      = 4,
   parameter int N_AW       = 7,
   parameter int N_WC       = 7,
   parameter int N_RC       = 7,
   parameter int N_AA       = 7,
   parameter int N_OE       = 4,
   parameter bit TRACK_TURN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              ld_wdata,
   output logic              drv_en,
   output logic              cap_en,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr
);

   // derived sequencing counts
   localparam int unsigned TURN_F  = N_WHZ;
   localparam int unsigned TURN_S  = umax(N_WHZ, N_OHZ);
   localparam int unsigned AW_M1   = (N_AW > 1) ? N_AW - 1 : 1;
   localparam int unsigned PULSE_F = umax(umax(N_WP, TURN_F + N_DW), AW_M1);
   localparam int unsigned PULSE_S = umax(umax(N_WP, TURN_S + N_DW), AW_M1);
   localparam int unsigned DATA_F  = PULSE_F - TURN_F;
   localparam int unsigned DATA_S  = PULSE_S - TURN_S;
   localparam int unsigned TAIL_F  = (N_WC > PULSE_F + 1) ? N_WC - 1 - PULSE_F : 1;
   localparam int unsigned TAIL_S  = (N_WC > PULSE_S + 1) ? N_WC - 1 - PULSE_S : 1;
   localparam int unsigned ACC     = umax(N_AA, N_OE);
   localparam int unsigned RTAIL   = (N_RC > ACC) ? N_RC - ACC : 0;
   localparam int unsigned TMAX    = umax(umax(PULSE_S, umax(TAIL_F, TAIL_S)), umax(ACC, RTAIL));
   localparam int          TW      = $clog2(TMAX + 2);
   localparam int          CW      = $clog2(PULSE_S + 2);

   seq_state_e        st_q, st_d;
   logic              tmr_ld;
   logic [TW-1:0]     tmr_ld_val, tmr_q, tmr_d, data_cyc;
   logic              tmr_zero;
   logic              ce_d, we_d, oe_d, drv_d;
   logic              ce_n_q, we_n_q, oe_n_q, drv_q;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              slow_path;
   logic              accept;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready & req_valid;
   assign ld_wdata  = accept & req_write;
   assign cap_en    = (st_q == ST_RACCESS) & tmr_zero;

   sram_down_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_ld),
      .load_val (tmr_ld_val),
      .cnt      (tmr_q),
      .zero     (tmr_zero)
   );

   // turnaround variant: remember the last operation, or always assume a read
   generate
      if (TRACK_TURN) begin : g_track
         logic last_rd_q;
         always_ff @(posedge clk) begin
            if (rst)
               last_rd_q <= 1'b0;
            else if (cap_en)
               last_rd_q <= 1'b1;
            else if ((st_q == ST_WPULSE) && tmr_zero)
               last_rd_q <= 1'b0;
         end
         assign slow_path = last_rd_q;
      end else begin : g_fixed
         assign slow_path = 1'b1;
      end
   endgenerate

   assign data_cyc = slow_path ? TW'(DATA_S) : TW'(DATA_F);

   always_comb begin
      st_d       = st_q;
      tmr_ld     = 1'b0;
      tmr_ld_val = '0;
      ce_d       = ce_n_q;
      we_d       = we_n_q;
      oe_d       = oe_n_q;
      addr_d     = addr_q;
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               addr_d = req_addr;
               ce_d   = 1'b0;
               tmr_ld = 1'b1;
               if (req_write) begin
                  st_d       = ST_WSETUP;
                  tmr_ld_val = '0;
               end else begin
                  st_d       = ST_RACCESS;
                  oe_d       = 1'b0;
                  tmr_ld_val = TW'(ACC - 1);
               end
            end
         end
         ST_WSETUP: begin
            st_d       = ST_WPULSE;
            we_d       = 1'b0;
            tmr_ld     = 1'b1;
            tmr_ld_val = slow_path ? TW'(PULSE_S - 1) : TW'(PULSE_F - 1);
         end
         ST_WPULSE: begin
            if (tmr_zero) begin
               st_d       = ST_WRECOV;
               we_d       = 1'b1;
               tmr_ld     = 1'b1;
               tmr_ld_val = slow_path ? TW'(TAIL_S - 1) : TW'(TAIL_F - 1);
            end
         end
         ST_WRECOV: begin
            if (tmr_zero) begin
               st_d = ST_IDLE;
               ce_d = 1'b1;
            end
         end
         ST_RACCESS: begin
            if (tmr_zero) begin
               ce_d = 1'b1;
               oe_d = 1'b1;
               if (RTAIL > 0) begin
                  st_d       = ST_RTAIL;
                  tmr_ld     = 1'b1;
                  tmr_ld_val = TW'((RTAIL > 0) ? RTAIL - 1 : 0);
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         ST_RTAIL: begin
            if (tmr_zero)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign tmr_d = tmr_ld ? tmr_ld_val : (tmr_zero ? '0 : tmr_q - 1'b1);
   assign drv_d = (st_d == ST_WPULSE) && (tmr_d < data_cyc);

   // all pin drivers are flops loaded from next-state values
   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         ce_n_q <= 1'b1;
         we_n_q <= 1'b1;
         oe_n_q <= 1'b1;
         drv_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         st_q   <= st_d;
         ce_n_q <= ce_d;
         we_n_q <= we_d;
         oe_n_q <= oe_d;
         drv_q  <= drv_d;
         addr_q <= addr_d;
      end
   end

   assign mem_ce_n = ce_n_q;
   assign mem_we_n = we_n_q;
   assign mem_oe_n = oe_n_q;
   assign mem_addr = addr_q;
   assign drv_en   = drv_q;

   // checker state: run lengths of the strobe and the driver
   logic [CW-1:0] we_low_cnt, drv_cnt;
   always_ff @(posedge clk) begin
      if (rst) begin
         we_low_cnt <= '0;
         drv_cnt    <= '0;
      end else begin
         we_low_cnt <= we_n_q ? '0 : we_low_cnt + 1'b1;
         drv_cnt    <= drv_q ? drv_cnt + 1'b1 : (we_n_q ? '0 : drv_cnt);
      end
   end

   p_rst_pins_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_ce_n && mem_we_n && mem_oe_n && !drv_en));

   p_standby_r2: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> mem_ce_n);

   p_we_qual_r3: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n));

   p_oe_qual_r3: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n && !drv_en));

   p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!mem_we_n || $rose(mem_we_n)) |-> $stable(mem_addr));

   p_drv_turn_r5: assert property (@(posedge clk) disable iff (rst)
      drv_en |-> (!mem_we_n && mem_oe_n && (we_low_cnt >= CW'(TURN_F))));

   p_drv_release_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> !drv_en);

   p_pulse_len_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> ((we_low_cnt >= CW'(N_WP)) && (drv_cnt >= CW'(N_DW))));

   p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_wdata,
   input  logic [DATA_W-1:0] wdata,
   input  logic              drv_en,
   input  logic              cap_en,
   inout  wire [DATA_W-1:0]  mem_dq,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [DATA_W-1:0] wd_q;

   always_ff @(posedge clk) begin
      if (rst)
         wd_q <= '0;
      else if (ld_wdata)
         wd_q <= wdata;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_drv
         assign mem_dq[b] = drv_en ? wd_q[b] : 1'bz;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap_en;
         if (cap_en)
            rd_data <= mem_dq;
      end
   end

   p_rdv_single_r7: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 8,
   parameter int T_WC_NS       = 55,
   parameter int T_WP_NS       = 40,
   parameter int T_AW_NS       = 55,
   parameter int T_DW_NS       = 25,
   parameter int T_WHZ_NS      = 20,
   parameter int T_OHZ_NS      = 30,
   parameter int T_RC_NS       = 55,
   parameter int T_AA_NS       = 55,
   parameter int T_OE_NS       = 30,
   parameter bit TRACK_TURN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire [DATA_W-1:0]  mem_dq
);

   localparam int N_WC  = ns_to_cyc(T_WC_NS,  CLK_PERIOD_NS);
   localparam int N_WP  = ns_to_cyc(T_WP_NS,  CLK_PERIOD_NS);
   localparam int N_AW  = ns_to_cyc(T_AW_NS,  CLK_PERIOD_NS);
   localparam int N_DW  = ns_to_cyc(T_DW_NS,  CLK_PERIOD_NS);
   localparam int N_WHZ = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
   localparam int N_OHZ = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
   localparam int N_RC  = ns_to_cyc(T_RC_NS,  CLK_PERIOD_NS);
   localparam int N_AA  = ns_to_cyc(T_AA_NS,  CLK_PERIOD_NS);
   localparam int N_OE  = ns_to_cyc(T_OE_NS,  CLK_PERIOD_NS);

   initial begin
      assert (CLK_PERIOD_NS > 0) else $fatal(1, "clock period must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $fatal(1, "bus widths must be positive");
   end

   logic ld_wdata, drv_en, cap_en;

   sram_seq #(
      .ADDR_W     (ADDR_W),
      .N_WP       (N_WP),
      .N_DW       (N_DW),
      .N_WHZ      (N_WHZ),
      .N_OHZ      (N_OHZ),
      .N_AW       (N_AW),
      .N_WC       (N_WC),
      .N_RC       (N_RC),
      .N_AA       (N_AA),
      .N_OE       (N_OE),
      .TRACK_TURN (TRACK_TURN)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_ready (req_ready),
      .ld_wdata  (ld_wdata),
      .drv_en    (drv_en),
      .cap_en    (cap_en),
      .mem_ce_n  (mem_ce_n),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .mem_addr  (mem_addr)
   );

   sram_dq_path #(.DATA_W(DATA_W)) u_dq (
      .clk      (clk),
      .rst      (rst),
      .ld_wdata (ld_wdata),
      .wdata    (req_wdata),
      .drv_en   (drv_en),
      .cap_en   (cap_en),
      .mem_dq   (mem_dq),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr  = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic        mem_ce_n, mem_we_n, mem_oe_n;
   logic [14:0] mem_addr;
   wire  [7:0]  mem_dq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit prev_read = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sram_async_ctrl u_sram_async_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
   );

   // memory model: 256 bytes indexed by the low address byte
   logic [7:0] model [0:255];
   logic [7:0] pend;
   int         oe_cnt = 0;
   logic       rd_on;
   logic [7:0] rd_byte;

   assign rd_on   = !mem_ce_n && mem_we_n && !mem_oe_n;
   assign rd_byte = (oe_cnt >= 7) ? model[mem_addr[7:0]] : ~model[mem_addr[7:0]];
   assign mem_dq  = rd_on ? rd_byte : 8'hzz;

   initial for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'hA5;

   always @(negedge clk) begin
      if (rd_on) oe_cnt <= oe_cnt + 1; else oe_cnt <= 0;
      if (!mem_ce_n && !mem_we_n) pend <= mem_dq;
   end

   always @(posedge mem_we_n) if (mem_ce_n === 1'b0) model[mem_addr[7:0]] = pend;

   // pin protocol monitors
   int viol_strobe = 0, viol_addr = 0, viol_stby = 0;
   bit prev_we_low = 1'b0;
   logic [14:0] prev_addr = '0;
   always @(negedge clk) begin
      if (!rst) begin
         if (!mem_we_n && (!mem_oe_n || mem_ce_n)) viol_strobe++;
         if (!mem_oe_n && (mem_ce_n || !mem_we_n)) viol_strobe++;
         if ((!mem_we_n || prev_we_low) && mem_addr != prev_addr) viol_addr++;
         if (req_ready && !mem_ce_n) viol_stby++;
      end
      prev_we_low = !mem_we_n;
      prev_addr   = mem_addr;
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // write one byte; counts busy cycles, strobe cycles and driver window
   task automatic do_write(input logic [14:0] a, input logic [7:0] d);
      int busy = 0, lows = 0, match = 0, first = -1;
      int e_pulse = prev_read ? 8 : 7;
      int e_turn  = prev_read ? 4 : 3;
      int e_busy  = prev_read ? 10 : 9;
      check(req_ready == 1'b1, "R9", "ready before write", int'(req_ready), 1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready && busy < 60) begin
         busy++;
         if (!mem_we_n) begin
            if (mem_dq === d) begin
               if (first < 0) first = lows;
               match++;
            end
            lows++;
         end
         @(negedge clk);
      end
      check(busy == e_busy, prev_read ? "R11" : "R10", "write busy cycles", busy, e_busy);
      check(lows == e_pulse, prev_read ? "R11" : "R6", "strobe low cycles", lows, e_pulse);
      check(first == e_turn, prev_read ? "R11" : "R5", "cycles before bus driven", first, e_turn);
      check(match == 4, "R6", "driven data cycles", match, 4);
      check(mem_ce_n == 1'b1, "R2", "standby after write", int'(mem_ce_n), 1);
      prev_read = 1'b0;
   endtask

   task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
      int lat = 1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rd_valid && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      check(lat == 8, "R7", "read valid latency", lat, 8);
      check(rd_data == exp, "R8", "read data", int'(rd_data), int'(exp));
      check(req_ready == 1'b1, "R10", "ready after read cycle", int'(req_ready), 1);
      @(negedge clk);
      check(rd_valid == 1'b0, "R7", "read valid width", int'(rd_valid), 0);
      prev_read = 1'b1;
   endtask

   // write a, while a different write is held on the inputs during busy
   task automatic do_ignored(input logic [14:0] a, input logic [7:0] d,
                             input logic [14:0] b, input logic [7:0] bd);
      int busy = 0;
      int e_busy = prev_read ? 10 : 9;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready && busy < 60) begin
         busy++;
         if (busy >= 2 && busy <= 5) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = b; req_wdata = bd;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(busy == e_busy, "R9", "busy with held request", busy, e_busy);
      prev_read = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n, "R1", "controls inactive in reset",
            int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
      check(rd_valid == 1'b0, "R1", "read valid in reset", int'(rd_valid), 0);
      check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
      rst = 1'b0;
      @(negedge clk);
      check(mem_ce_n == 1'b1, "R2", "standby after reset", int'(mem_ce_n), 1);

      do_write(15'h0011, 8'h5A);
      do_write(15'h0102, 8'h3C);
      do_read (15'h0011, 8'h5A);
      do_write(15'h0203, 8'h96);          // write after read: R11
      do_read (15'h0102, 8'h3C);
      do_read (15'h0203, 8'h96);
      do_read (15'h0044, 8'h44 ^ 8'hA5);  // untouched location
      do_ignored(15'h0055, 8'h77, 15'h0066, 8'h18);
      do_read (15'h0066, 8'h66 ^ 8'hA5);  // R9: held request ignored
      do_read (15'h0055, 8'h77);
      do_write(15'h7FFF, 8'hF0);
      do_read (15'h7FFF, 8'hF0);

      check(viol_strobe == 0, "R3", "strobe qualification violations", viol_strobe, 0);
      check(viol_addr == 0, "R4", "address changes around strobe", viol_addr, 0);
      check(viol_stby == 0, "R2", "idle cycles without standby", viol_stby, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule